// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block gives a processor 24 general-purpose parallel I/O lines, organised as two full 8-bit ports (A and B) and a third 8-bit port (C). Port C splits into an upper and a lower nibble, and each nibble has its own direction. For direction control, the upper nibble of C is grouped with port A and the lower nibble with port B. The processor reaches the ports and a control register over an 8-bit data bus. It selects the target with two address bits and uses active-low chip-select, read and write strobes.

Every line has an output latch, an output value and an output enable, which sit beside its input pin. Input pins pass through a short synchroniser and are sampled whenever a read selects them. A control word either reconfigures the directions of the four port sections, or sets or clears a single bit of port C. Only basic I/O is supported; there are no handshake or bidirectional modes. The bus strobes are sampled on the block clock, and a write commits on the clock edge that first sees the write strobe high again.

Top module: `pio24_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it falls, every output enable of ports A, B and C is 0 (all lines are inputs) and every output latch reads as zero.
- R2: The address selects the target as follows: 2'b00 is port A, 2'b01 is port B, 2'b10 is port C and 2'b11 is the control register.
- R3: A control-register write with bit 7 = 1 is a mode word. Bit 4 sets the direction of port A, bit 3 the upper nibble of C, bit 1 port B and bit 0 the lower nibble of C, where 1 means input (enables off) and 0 means output (enables on).
- R4: A mode word in which bit 6, bit 5 or bit 2 is nonzero is ignored: it changes neither the directions nor the latches.
- R5: A valid mode word clears the output latches of all three ports to zero.
- R6: A control-register write with bit 7 = 0 sets or clears one bit of port C. Bits 3:1 give the bit index and bit 0 gives the new value. The other bits of port C are unchanged.
- R7: A write commits once, on the first clock edge at which wr_n is sampled high after being sampled low, using the chip select, address and data sampled while wr_n was low. No write commits if cs_n was high.
- R8: A read of a section configured as input returns that section's pin values, as sampled through a PIN_SYNC-stage synchroniser.
- R9: A read of a section configured as output returns that section's output latch.
- R10: rdata_oe is 1 exactly when cs_n and rd_n are both low; otherwise rdata_oe is 0 and rdata is zero.
- R11: The two nibbles of port C take independent directions, so a read of C combines pins for an input nibble with the latch for an output nibble.
- R12: A read of the control address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target select |
| wdata | input | BUS_W | Write data from the processor |
| rdata | output | BUS_W | Read data to the processor |
| rdata_oe | output | 1 | Read data drive enable for the bus |
| pa_in | input | PORT_W | Port A pin values |
| pa_out | output | PORT_W | Port A output values |
| pa_oe | output | PORT_W | Port A per-line output enable |
| pb_in | input | PORT_W | Port B pin values |
| pb_out | output | PORT_W | Port B output values |
| pb_oe | output | PORT_W | Port B per-line output enable |
| pc_in | input | PORT_W | Port C pin values |
| pc_out | output | PORT_W | Port C output values |
| pc_oe | output | PORT_W | Port C per-line output enable |

## Verification
Port reads are tried in three settings. With all ports as inputs, the distinct pin patterns 5A, C3 and A5 reveal any crossed address decode. With all ports as outputs, the different latch values show whether the read path picks the latch. In the mixed settings with split nibbles of port C, a read of A5 pins against a 3C latch yields AC only when each nibble takes its own source. Mode words with reserved bits set, a write with chip select high and bit set/reset commands at both ends of port C separate the ignored cases from the committed ones.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef enum logic [1:0] {
      SEL_A   = 2'b00,
      SEL_B   = 2'b01,
      SEL_C   = 2'b10,
      SEL_CTL = 2'b11
   } pio_sel_e;

   typedef struct packed {
      logic a_in;
      logic cu_in;
      logic b_in;
      logic cl_in;
   } pio_dir_t;

   localparam int CW_KIND   = 7;
   localparam int CW_DIR_A  = 4;
   localparam int CW_DIR_CU = 3;
   localparam int CW_DIR_B  = 1;
   localparam int CW_DIR_CL = 0;
   localparam int CW_RSV_HI = 6;
   localparam int CW_RSV_LO = 5;
   localparam int CW_RSV_M  = 2;
   localparam int CW_IDX_LO = 1;
   localparam int CW_IDX_W  = 3;
   localparam int CW_VAL    = 0;

   localparam pio_dir_t DIR_ALL_IN = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

   function automatic logic mode_word_ok(input logic [7:0] cw);
      return cw[CW_KIND] && !cw[CW_RSV_HI] && !cw[CW_RSV_LO] && !cw[CW_RSV_M];
   endfunction

   function automatic pio_dir_t mode_to_dir(input logic [7:0] cw);
      pio_dir_t d;
      d.a_in  = cw[CW_DIR_A];
      d.cu_in = cw[CW_DIR_CU];
      d.b_in  = cw[CW_DIR_B];
      d.cl_in = cw[CW_DIR_CL];
      return d;
   endfunction

endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if
   import pio_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic             commit,
   output pio_sel_e         cmt_sel,
   output logic [BUS_W-1:0] cmt_data,
   output logic             rd_active
);

   logic wr_lo_q;
   logic cap_cs_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_lo_q  <= 1'b0;
         cap_cs_q <= 1'b0;
         cmt_sel  <= SEL_A;
         cmt_data <= '0;
      end else begin
         wr_lo_q <= !wr_n;
         if (!wr_n) begin
            cap_cs_q <= !cs_n;
            cmt_sel  <= pio_sel_e'(addr);
            cmt_data <= wdata;
         end
      end
   end

   assign commit    = wr_lo_q && wr_n && cap_cs_q;
   assign rd_active = !cs_n && !rd_n;

   a_r7_single_commit: assert property (@(posedge clk) disable iff (rst)
      commit |=> !commit)
      else $error("R7: write committed on two consecutive edges");

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
   import pio_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int PORT_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              commit,
   input  pio_sel_e          cmt_sel,
   input  logic [BUS_W-1:0]  cmt_data,
   output pio_dir_t          dir,
   output logic [PORT_W-1:0] lat_a,
   output logic [PORT_W-1:0] lat_b,
   output logic [PORT_W-1:0] lat_c
);

   localparam int IDX_MAX = 1 << CW_IDX_W;

   logic [7:0]          cw;
   logic [CW_IDX_W-1:0] bsr_idx;
   logic                bsr_val;
   logic                is_mode;
   logic                mode_ok;
   logic [PORT_W-1:0]   lat_c_bsr;
   logic [PORT_W-1:0]   port_wr;

   assign cw      = cmt_data[7:0];
   assign bsr_idx = cw[CW_IDX_LO +: CW_IDX_W];
   assign bsr_val = cw[CW_VAL];
   assign is_mode = cw[CW_KIND];
   assign mode_ok = mode_word_ok(cw);
   assign port_wr = cmt_data[PORT_W-1:0];

   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_bsr
         if (i < IDX_MAX) begin : g_sel
            assign lat_c_bsr[i] = (bsr_idx == CW_IDX_W'(i)) ? bsr_val : lat_c[i];
         end else begin : g_keep
            assign lat_c_bsr[i] = lat_c[i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         dir   <= DIR_ALL_IN;
         lat_a <= '0;
         lat_b <= '0;
         lat_c <= '0;
      end else if (commit) begin
         unique case (cmt_sel)
            SEL_A: lat_a <= port_wr;
            SEL_B: lat_b <= port_wr;
            SEL_C: lat_c <= port_wr;
            SEL_CTL: begin
               if (is_mode) begin
                  if (mode_ok) begin
                     dir   <= mode_to_dir(cw);
                     lat_a <= '0;
                     lat_b <= '0;
                     lat_c <= '0;
                  end
               end else begin
                  lat_c <= lat_c_bsr;
               end
            end
         endcase
      end
   end

   a_r7_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
      !commit |=> $stable(dir) && $stable(lat_a) && $stable(lat_b) && $stable(lat_c))
      else $error("R7: port state changed without a committed write");

   a_r5_mode_clears: assert property (@(posedge clk) disable iff (rst)
      (commit && cmt_sel == SEL_CTL && cw[CW_KIND] && !cw[CW_RSV_HI] && !cw[CW_RSV_LO] && !cw[CW_RSV_M])
      |=> (lat_a == '0 && lat_b == '0 && lat_c == '0))
      else $error("R5: latches not cleared by a mode word");

   a_r6_single_bit: assert property (@(posedge clk) disable iff (rst)
      (commit && cmt_sel == SEL_CTL && !cw[CW_KIND])
      |=> ($countones(lat_c ^ $past(lat_c)) <= 1 && $stable(lat_a) && $stable(lat_b)))
      else $error("R6: bit set/reset touched more than one bit");

   a_r4_bad_mode_ignored: assert property (@(posedge clk) disable iff (rst)
      (commit && cmt_sel == SEL_CTL && cw[CW_KIND] && (cw[CW_RSV_HI] || cw[CW_RSV_LO] || cw[CW_RSV_M]))
      |=> ($stable(dir) && $stable(lat_a) && $stable(lat_b) && $stable(lat_c)))
      else $error("R4: reserved mode word took effect");

endmodule

// File: rtl/pio_section.sv
module pio_section #(
   parameter int W        = 8,
   parameter int PIN_SYNC = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         is_input,
   input  logic [W-1:0] latch,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe,
   output logic [W-1:0] rd_val
);

   logic [W-1:0] pin_s;

   generate
      if (PIN_SYNC == 0) begin : g_raw
         assign pin_s = pin_in;
      end else begin : g_sync
         logic [PIN_SYNC-1:0][W-1:0] chain;
         always_ff @(posedge clk) begin
            chain[0] <= pin_in;
            for (int i = 1; i < PIN_SYNC; i++) chain[i] <= chain[i-1];
         end
         assign pin_s = chain[PIN_SYNC-1];
      end
   endgenerate

   assign pin_out = latch;
   assign pin_oe  = {W{!is_input}};
   assign rd_val  = is_input ? pin_s : latch;

   a_r1_inputs_after_reset: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pin_oe == '0 && pin_out == '0))
      else $error("R1: section driving or latch nonzero after reset");

endmodule

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
   import pio_pkg::*;
#(
   parameter int BUS_W    = 8,
   parameter int PORT_W   = 8,
   parameter int PIN_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   output logic              rdata_oe,
   input  logic [PORT_W-1:0] pa_in,
   output logic [PORT_W-1:0] pa_out,
   output logic [PORT_W-1:0] pa_oe,
   input  logic [PORT_W-1:0] pb_in,
   output logic [PORT_W-1:0] pb_out,
   output logic [PORT_W-1:0] pb_oe,
   input  logic [PORT_W-1:0] pc_in,
   output logic [PORT_W-1:0] pc_out,
   output logic [PORT_W-1:0] pc_oe
);

   localparam int HALF = PORT_W / 2;

   generate
      if (BUS_W < 8)             begin : g_bad_bus  $error("BUS_W must hold a control word"); end
      if (PORT_W > BUS_W)        begin : g_bad_port $error("PORT_W must fit on the bus"); end
      if (PORT_W % 2 != 0)       begin : g_bad_half $error("PORT_W must split into two halves"); end
      if (PIN_SYNC < 0)          begin : g_bad_sync $error("PIN_SYNC must not be negative"); end
   endgenerate

   logic              commit;
   pio_sel_e          cmt_sel;
   logic [BUS_W-1:0]  cmt_data;
   logic              rd_active;
   pio_dir_t          dir;
   logic [PORT_W-1:0] lat_a, lat_b, lat_c;
   logic [PORT_W-1:0] rv_a, rv_b, rv_c;
   logic [BUS_W-1:0]  rd_mux;

   pio_bus_if #(.BUS_W(BUS_W)) u_bus (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .commit(commit), .cmt_sel(cmt_sel),
      .cmt_data(cmt_data), .rd_active(rd_active)
   );

   pio_ctrl #(.BUS_W(BUS_W), .PORT_W(PORT_W)) u_ctrl (
      .clk(clk), .rst(rst), .commit(commit), .cmt_sel(cmt_sel),
      .cmt_data(cmt_data), .dir(dir), .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c)
   );

   pio_section #(.W(PORT_W), .PIN_SYNC(PIN_SYNC)) u_sec_a (
      .clk(clk), .rst(rst), .is_input(dir.a_in), .latch(lat_a), .pin_in(pa_in),
      .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rv_a)
   );

   pio_section #(.W(PORT_W), .PIN_SYNC(PIN_SYNC)) u_sec_b (
      .clk(clk), .rst(rst), .is_input(dir.b_in), .latch(lat_b), .pin_in(pb_in),
      .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rv_b)
   );

   pio_section #(.W(HALF), .PIN_SYNC(PIN_SYNC)) u_sec_cu (
      .clk(clk), .rst(rst), .is_input(dir.cu_in), .latch(lat_c[PORT_W-1:HALF]),
      .pin_in(pc_in[PORT_W-1:HALF]), .pin_out(pc_out[PORT_W-1:HALF]),
      .pin_oe(pc_oe[PORT_W-1:HALF]), .rd_val(rv_c[PORT_W-1:HALF])
   );

   pio_section #(.W(HALF), .PIN_SYNC(PIN_SYNC)) u_sec_cl (
      .clk(clk), .rst(rst), .is_input(dir.cl_in), .latch(lat_c[HALF-1:0]),
      .pin_in(pc_in[HALF-1:0]), .pin_out(pc_out[HALF-1:0]),
      .pin_oe(pc_oe[HALF-1:0]), .rd_val(rv_c[HALF-1:0])
   );

   always_comb begin
      rd_mux = '0;
      unique case (pio_sel_e'(addr))
         SEL_A:   rd_mux[PORT_W-1:0] = rv_a;
         SEL_B:   rd_mux[PORT_W-1:0] = rv_b;
         SEL_C:   rd_mux[PORT_W-1:0] = rv_c;
         SEL_CTL: rd_mux = '0;
      endcase
   end

   assign rdata_oe = rd_active;
   assign rdata    = rd_active ? rd_mux : '0;

   a_r3_dir_follows_mode: assert property (@(posedge clk) disable iff (rst)
      (commit && cmt_sel == SEL_CTL && mode_word_ok(cmt_data[7:0]))
      |=> (pa_oe == {PORT_W{!$past(cmt_data[CW_DIR_A])}} && pb_oe == {PORT_W{!$past(cmt_data[CW_DIR_B])}}))
      else $error("R3: port enables do not follow the mode word");

endmodule

// File: tb/test_pio24_ctrl.sv
module test_pio24_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'b00;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       rdata_oe;
   logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   bit mon_go = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   pio24_ctrl i_pio24_ctrl (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data and compares in the low clock phase
   always begin
      @(negedge clk);
      #1;
      if (mon_go) begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check({t, " rdata_oe"}, {7'b0, rdata_oe}, 8'h01);
         check(t, rdata, e);
      end
   end

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_low);
      @(negedge clk);
      cs_n = !sel_low; addr = a; wdata = d; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      cs_n = 1'b0; rd_n = 1'b0; addr = a; mon_go = 1'b1;
      @(negedge clk);
      mon_go = 1'b0; cs_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'hA5;
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1 pa_oe", pa_oe, 8'h00);
      check("R1 pb_oe", pb_oe, 8'h00);
      check("R1 pc_oe", pc_oe, 8'h00);
      check("R1 pa_out", pa_out, 8'h00);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 idle oe", {7'b0, rdata_oe}, 8'h00);
      check("R10 idle rdata", rdata, 8'h00);
      // R8 / R2: inputs after reset, distinct pin patterns per port
      bus_read(2'b00, 8'h5A, "R8 R2 read A pins");
      bus_read(2'b01, 8'hC3, "R8 R2 read B pins");
      bus_read(2'b10, 8'hA5, "R8 R2 read C pins");
      // R10: read strobe without chip select
      @(negedge clk); rd_n = 1'b0; addr = 2'b00;
      #1 check("R10 rd without cs", {7'b0, rdata_oe}, 8'h00);
      @(negedge clk); rd_n = 1'b1;
      // R3: all outputs
      bus_write(2'b11, 8'h80, 1'b1);
      check("R3 pa_oe", pa_oe, 8'hFF);
      check("R3 pb_oe", pb_oe, 8'hFF);
      check("R3 pc_oe", pc_oe, 8'hFF);
      // R2: address decode on writes
      bus_write(2'b00, 8'h11, 1'b1);
      bus_write(2'b01, 8'h22, 1'b1);
      bus_write(2'b10, 8'h33, 1'b1);
      check("R2 pa_out", pa_out, 8'h11);
      check("R2 pb_out", pb_out, 8'h22);
      check("R2 pc_out", pc_out, 8'h33);
      bus_read(2'b00, 8'h11, "R9 read A latch");
      bus_read(2'b10, 8'h33, "R9 read C latch");
      // R6: bit set/reset at both ends of port C
      bus_write(2'b11, 8'h0F, 1'b1);
      check("R6 set bit 7", pc_out, 8'hB3);
      bus_write(2'b11, 8'h00, 1'b1);
      check("R6 clear bit 0", pc_out, 8'hB2);
      check("R6 A untouched", pa_out, 8'h11);
      // R7: write with chip select high ignored
      bus_write(2'b00, 8'h77, 1'b0);
      check("R7 cs high write", pa_out, 8'h11);
      // R4: reserved mode words ignored
      bus_write(2'b11, 8'hC0, 1'b1);
      bus_write(2'b11, 8'h9E, 1'b1);
      check("R4 pa_oe kept", pa_oe, 8'hFF);
      check("R4 pb_oe kept", pb_oe, 8'hFF);
      check("R4 latch kept", pa_out, 8'h11);
      // R12: control address reads zero
      bus_read(2'b11, 8'h00, "R12 read control");
      // R5 / R11: upper C input, rest output
      bus_write(2'b11, 8'h88, 1'b1);
      check("R5 A cleared", pa_out, 8'h00);
      check("R5 C cleared", pc_out, 8'h00);
      check("R11 pc_oe split", pc_oe, 8'h0F);
      check("R3 pa_oe out", pa_oe, 8'hFF);
      bus_write(2'b10, 8'h3C, 1'b1);
      check("R11 pc_out", pc_out, 8'h3C);
      bus_read(2'b10, 8'hAC, "R11 mixed C read");
      // R3: A and B input, C output
      bus_write(2'b11, 8'h92, 1'b1);
      check("R3 pa_oe in", pa_oe, 8'h00);
      check("R3 pb_oe in", pb_oe, 8'h00);
      check("R3 pc_oe out", pc_oe, 8'hFF);
      bus_read(2'b00, 8'h5A, "R8 A input again");
      // R11: lower C input only
      bus_write(2'b11, 8'h81, 1'b1);
      check("R11 pc_oe lower in", pc_oe, 8'hF0);
      bus_read(2'b10, 8'h05, "R11 lower pins upper latch");
      pc_in = 8'h5E;
      repeat (4) @(negedge clk);
      bus_read(2'b10, 8'h0E, "R8 C lower new pins");
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) check("scoreboard drained", 8'(exp_q.size()), 8'h00);
      finish_run();
   end

endmodule